// File: doc/BRIEF.md
# Dot-Matrix Display Refresh Sequencer

This block drives an eight-position LED display in which every position is a 5-column by 7-row dot matrix. It holds one 8-bit code per position. Each cycle it turns the code into the lit columns of the row being scanned. The rows are scanned one at a time, so all eight positions share the same row lines.

The top bit of a code selects where the pixels come from. When it is clear, the low seven bits pick a glyph from a built-in character table. When it is set, the low four bits pick one of sixteen glyphs that software has written into a user glyph memory.

On top of the scanned image the block applies three things, in this priority order:
- a lamp test that lights every LED;
- a whole-display blink at 2 Hz;
- the normal image.

The row scan is paced by one of two sources:
- an internal divider, which the block also presents on a sync output so that other displays can follow it;
- rising edges on a sync input that another display provides.

Top module: `dmx_scan_sequencer`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, row_o is 7'b0000001 (row 0 selected), every code and every user glyph row is zero, and the blink phase is visible. With no lamp test, col_o is therefore all zeros.
- R2: With clk_sel_i=1, sync_o pulses high for one cycle every ROW_DWELL cycles. Counting from reset, the first pulse falls in cycle ROW_DWELL-1. In the cycle after each pulse row_o moves from row r to row r+1, and from row 6 back to row 0. row_o is always one-hot, and bit r selects row r.
- R3: With clk_sel_i=0, sync_o stays 0 and the internal divider does not move the row. The row advances one cycle after each rising edge of sync_i, which is sampled on clk_i. A high or low level held on sync_i does not advance the row.
- R4: A code whose bit 7 is 0 shows a table glyph chosen by bits 6:0, as listed below. Every other 7-bit code shows blank.
  - 7'h48: rows 0-2 and 4-6 show 5'b10001, and row 3 shows 5'b11111.
  - 7'h2D: row 3 shows 5'b11111, and the other rows are blank.
  - 7'h7F: every row shows 5'b11111.
- R5: A code whose bit 7 is 1 shows user glyph number bits 3:0. Bits 6:4 of such a code are ignored.
- R6: When udc_we_i is high, udc_data_i is stored as row udc_row_i of user glyph udc_sel_i, and it is visible from the next cycle. Row index 7 is ignored.
- R7: Position d drives col_o[39-5d -: 5], so position 0 is the leftmost and sits at the most significant end. Within a position, bit 4 is the leftmost column. A set bit lights the LED.
- R8: The blink phase toggles every CLK_HZ/(2*BLINK_HZ) cycles. While blink_en_i=1 and the phase is dark, col_o is all zeros, and row scanning continues.
- R9: With blink_en_i=0, the blink phase has no effect on col_o.
- R10: With test_en_i=1, col_o is all ones regardless of blink or codes, and row scanning continues.
- R11: When char_we_i is high, char_data_i is stored as the code for position char_addr_i, and it is visible on col_o from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_sel_i | input | 1 | 1: internal row pacing, 0: follow sync_i |
| sync_i | input | 1 | Row-advance pulse from another display |
| sync_o | output | 1 | Internal row-advance pulse |
| blink_en_i | input | 1 | Enable whole-display blink |
| test_en_i | input | 1 | Lamp test, all LEDs lit |
| char_we_i | input | 1 | Code write strobe |
| char_addr_i | input | 3 | Position written |
| char_data_i | input | 8 | Code written |
| udc_we_i | input | 1 | User glyph write strobe |
| udc_sel_i | input | 4 | User glyph number |
| udc_row_i | input | 3 | User glyph row |
| udc_data_i | input | 5 | User glyph row pattern |
| row_o | output | 7 | One-hot row select |
| col_o | output | 40 | Column pattern for all positions |

## Verification
The column and sync outputs are combinational from registered state. Writes, row steps and blink toggles therefore appear one cycle after the clock edge that samples them. The divider pulse on sync_o appears in the same cycle as the divider reaches its terminal count.

A behavioural model in the bench steps its own counters on every rising edge, using the inputs the bench drove at the preceding falling edge. It compares row_o, col_o and sync_o against the model on every falling edge, before new inputs are applied. This way each result is checked in exactly the cycle it is due.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int GLYPH_COLS = 5;
  localparam int GLYPH_ROWS = 7;
  localparam int ROW_W      = 3;
  localparam int UIDX_W     = 4;
  localparam int UDC_N      = 1 << UIDX_W;
  localparam int CODE_W     = 8;

  typedef logic [GLYPH_COLS-1:0] row_bits_t;

  // Small built-in font: H, dash, solid block; all else blank
  function automatic row_bits_t ascii_row(input logic [6:0] code,
                                          input logic [ROW_W-1:0] row);
    row_bits_t r;
    case (code)
      7'h48:   r = (row == 3'd3) ? 5'b11111 : 5'b10001;
      7'h2D:   r = (row == 3'd3) ? 5'b11111 : 5'b00000;
      7'h7F:   r = 5'b11111;
      default: r = 5'b00000;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dmx_scan_timer.sv
module dmx_scan_timer #(
  parameter int ROW_DWELL = 64,
  parameter int ROWS      = 7,
  localparam int DW = (ROW_DWELL > 1) ? $clog2(ROW_DWELL) : 1,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clk_sel_i,
  input  logic          sync_i,
  output logic          int_tick_o,
  output logic [RW-1:0] row_idx_o
);
  logic [DW-1:0] div_q;
  logic          sync_q;
  logic          ext_tick, tick;

  assign int_tick_o = (div_q == DW'(ROW_DWELL-1));
  assign ext_tick   = !clk_sel_i && sync_i && !sync_q;
  assign tick       = clk_sel_i ? int_tick_o : ext_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      sync_q    <= 1'b0;
      row_idx_o <= '0;
    end else begin
      div_q  <= int_tick_o ? '0 : div_q + 1'b1;
      sync_q <= sync_i;
      if (tick)
        row_idx_o <= (row_idx_o == RW'(ROWS-1)) ? '0 : row_idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/dmx_blink_timer.sv
module dmx_blink_timer #(
  parameter int CLK_HZ   = 1_000_000,
  parameter int BLINK_HZ = 2,
  localparam int HALF = (CLK_HZ / (2*BLINK_HZ) > 0) ? CLK_HZ / (2*BLINK_HZ) : 1,
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic on_o
);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      on_o  <= 1'b1;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) on_o <= !on_o;
    end
  end
endmodule

// File: rtl/dmx_glyph_store.sv
module dmx_glyph_store
  import dmx_pkg::*;
#(
  parameter int DIGITS = 8,
  localparam int AW   = $clog2(DIGITS),
  localparam int COLW = DIGITS * GLYPH_COLS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  char_we_i,
  input  logic [AW-1:0]         char_addr_i,
  input  logic [CODE_W-1:0]     char_data_i,
  input  logic                  udc_we_i,
  input  logic [UIDX_W-1:0]     udc_sel_i,
  input  logic [ROW_W-1:0]      udc_row_i,
  input  logic [GLYPH_COLS-1:0] udc_data_i,
  input  logic [ROW_W-1:0]      row_idx_i,
  output logic [COLW-1:0]       cols_o
);
  logic [CODE_W-1:0] char_q [DIGITS];
  row_bits_t         udc_q  [UDC_N][1 << ROW_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < DIGITS; d++) char_q[d] <= '0;
      for (int g = 0; g < UDC_N; g++)
        for (int r = 0; r < (1 << ROW_W); r++) udc_q[g][r] <= '0;
    end else begin
      if (char_we_i) char_q[char_addr_i] <= char_data_i;
      if (udc_we_i && (udc_row_i < ROW_W'(GLYPH_ROWS)))
        udc_q[udc_sel_i][udc_row_i] <= udc_data_i;
    end
  end

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [CODE_W-1:0] code;
    row_bits_t         pat;
    assign code = char_q[d];
    assign pat  = code[CODE_W-1] ? udc_q[code[UIDX_W-1:0]][row_idx_i]
                                 : ascii_row(code[6:0], row_idx_i);
    // position 0 sits at the MSB end
    assign cols_o[(DIGITS-1-d)*GLYPH_COLS +: GLYPH_COLS] = pat;
  end
endmodule

// File: rtl/dmx_scan_sequencer.sv
module dmx_scan_sequencer
  import dmx_pkg::*;
#(
  parameter int DIGITS    = 8,
  parameter int ROW_DWELL = 64,
  parameter int CLK_HZ    = 1_000_000,
  parameter int BLINK_HZ  = 2,
  localparam int AW   = $clog2(DIGITS),
  localparam int COLW = DIGITS * GLYPH_COLS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clk_sel_i,
  input  logic                  sync_i,
  output logic                  sync_o,
  input  logic                  blink_en_i,
  input  logic                  test_en_i,
  input  logic                  char_we_i,
  input  logic [AW-1:0]         char_addr_i,
  input  logic [CODE_W-1:0]     char_data_i,
  input  logic                  udc_we_i,
  input  logic [UIDX_W-1:0]     udc_sel_i,
  input  logic [ROW_W-1:0]      udc_row_i,
  input  logic [GLYPH_COLS-1:0] udc_data_i,
  output logic [GLYPH_ROWS-1:0] row_o,
  output logic [COLW-1:0]       col_o
);
  logic [ROW_W-1:0] row_idx;
  logic             int_tick;
  logic             blink_on;
  logic [COLW-1:0]  glyph_cols;

  dmx_scan_timer #(.ROW_DWELL(ROW_DWELL), .ROWS(GLYPH_ROWS)) u_scan (
    .clk_i, .rst_ni, .clk_sel_i, .sync_i,
    .int_tick_o(int_tick), .row_idx_o(row_idx)
  );

  dmx_blink_timer #(.CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ)) u_blink (
    .clk_i, .rst_ni, .on_o(blink_on)
  );

  dmx_glyph_store #(.DIGITS(DIGITS)) u_store (
    .clk_i, .rst_ni, .char_we_i, .char_addr_i, .char_data_i,
    .udc_we_i, .udc_sel_i, .udc_row_i, .udc_data_i,
    .row_idx_i(row_idx), .cols_o(glyph_cols)
  );

  assign sync_o = clk_sel_i && int_tick;
  assign row_o  = GLYPH_ROWS'(1) << row_idx;

  // lamp test > blink > image
  always_comb begin
    if (test_en_i)                    col_o = '1;
    else if (blink_en_i && !blink_on) col_o = '0;
    else                              col_o = glyph_cols;
  end
endmodule

// File: rtl/dmx_scan_sequencer_chk.sv
module dmx_scan_sequencer_chk #(
  parameter int ROWS = 7,
  parameter int COLW = 40
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            clk_sel_i,
  input logic            sync_i,
  input logic            sync_o,
  input logic            test_en_i,
  input logic            blink_en_i,
  input logic            blink_on_i,
  input logic [ROWS-1:0] row_o,
  input logic [COLW-1:0] col_o
);
  p_row_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(row_o) == 1);

  p_row_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !$stable(row_o));

  p_sync_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_sel_i |-> !sync_o);

  p_ext_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_sel_i && $rose(sync_i)) |=> !$stable(row_o));

  p_ext_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_sel_i && !$rose(sync_i)) |=> $stable(row_o));

  p_blink_dark_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blink_en_i && !test_en_i && !blink_on_i) |-> (col_o == '0));

  p_lamp_test_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_en_i |-> (&col_o));
endmodule

bind dmx_scan_sequencer dmx_scan_sequencer_chk #(
  .ROWS(dmx_pkg::GLYPH_ROWS), .COLW(COLW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_sel_i(clk_sel_i), .sync_i(sync_i),
  .sync_o(sync_o), .test_en_i(test_en_i), .blink_en_i(blink_en_i),
  .blink_on_i(blink_on), .row_o(row_o), .col_o(col_o)
);

// File: tb/dmx_scan_sequencer_bench.sv
module dmx_scan_sequencer_bench;
  localparam int DIGITS = 8;
  localparam int DWELL  = 4;
  localparam int HZ     = 400;
  localparam int HALF   = HZ / 4;
  localparam int COLW   = DIGITS * 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_sel = 1'b1, sync_in = 1'b0, blink_en = 1'b0, test_en = 1'b0;
  logic char_we = 1'b0, udc_we = 1'b0;
  logic [2:0] char_addr = '0, udc_row = '0;
  logic [7:0] char_data = '0;
  logic [3:0] udc_sel = '0;
  logic [4:0] udc_data = '0;
  logic sync_o;
  logic [6:0] row_o;
  logic [COLW-1:0] col_o;

  always #2 clk = ~clk;

  dmx_scan_sequencer #(.DIGITS(DIGITS), .ROW_DWELL(DWELL), .CLK_HZ(HZ)) u_dmx_scan_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel), .sync_i(sync_in), .sync_o(sync_o),
    .blink_en_i(blink_en), .test_en_i(test_en), .char_we_i(char_we), .char_addr_i(char_addr),
    .char_data_i(char_data), .udc_we_i(udc_we), .udc_sel_i(udc_sel), .udc_row_i(udc_row),
    .udc_data_i(udc_data), .row_o(row_o), .col_o(col_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model
  int m_row, m_div, m_bcnt;
  bit m_on, m_syncq;
  logic [7:0] m_char [8];
  logic [4:0] m_udc [16][7];

  function automatic logic [4:0] font(input logic [6:0] c, input int r);
    if (c == 7'h48) return (r == 3) ? 5'h1F : 5'h11;
    if (c == 7'h2D) return (r == 3) ? 5'h1F : 5'h00;
    if (c == 7'h7F) return 5'h1F;
    return 5'h00;
  endfunction

  function automatic logic [COLW-1:0] exp_col();
    logic [COLW-1:0] v = '0;
    if (test_en) return '1;
    if (blink_en && !m_on) return '0;
    for (int d = 0; d < DIGITS; d++) begin
      logic [4:0] p;
      p = m_char[d][7] ? m_udc[m_char[d][3:0]][m_row] : font(m_char[d][6:0], m_row);
      v[COLW-1-5*d -: 5] = p;
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_row = 0; m_div = 0; m_bcnt = 0; m_on = 1; m_syncq = 0;
      for (int d = 0; d < 8; d++) m_char[d] = '0;
      for (int g = 0; g < 16; g++) for (int r = 0; r < 7; r++) m_udc[g][r] = '0;
    end else begin
      bit it, t;
      it = (m_div == DWELL-1);
      t  = clk_sel ? it : (sync_in && !m_syncq);
      m_div = it ? 0 : m_div + 1;
      m_syncq = sync_in;
      if (t) m_row = (m_row + 1) % 7;
      if (m_bcnt == HALF-1) begin m_bcnt = 0; m_on = !m_on; end
      else m_bcnt++;
      if (char_we) m_char[char_addr] = char_data;
      if (udc_we && udc_row < 7) m_udc[udc_sel][udc_row] = udc_data;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    logic [6:0] er;
    logic es;
    er = 7'd1 << m_row;
    es = clk_sel && (m_div == DWELL-1);
    checks += 3;
    if (row_o !== er) begin errors++; $display("FAIL %s row_o=%b exp %b", tag, row_o, er); end
    if (sync_o !== es) begin errors++; $display("FAIL %s sync_o=%b exp %b", tag, sync_o, es); end
    if (col_o !== exp_col()) begin errors++; $display("FAIL %s col_o=%h exp %h", tag, col_o, exp_col()); end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr_char(input int a, input logic [7:0] c);
    @(negedge clk); #1;
    char_we = 1; char_addr = 3'(a); char_data = c;
    @(negedge clk); #1;
    char_we = 0;
  endtask

  task automatic wr_udc(input int g, input int r, input logic [4:0] p);
    @(negedge clk); #1;
    udc_we = 1; udc_sel = 4'(g); udc_row = 3'(r); udc_data = p;
    @(negedge clk); #1;
    udc_we = 0;
  endtask

  initial begin
    #1; // R1: state during reset
    checks += 2;
    if (row_o !== 7'b0000001) begin errors++; $display("FAIL R1 row_o=%b exp %b", row_o, 7'b1); end
    if (col_o !== '0) begin errors++; $display("FAIL R1 col_o=%h exp 0", col_o); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    tag = "R2"; idle(40);
    tag = "R11"; wr_char(0, 8'h48); idle(3);
    tag = "R7"; idle(14);
    tag = "R4";
    wr_char(1, 8'h2D); wr_char(2, 8'h7F); wr_char(3, 8'h41); wr_char(7, 8'h48);
    idle(30);
    tag = "R6";
    for (int r = 0; r < 7; r++) wr_udc(5, r, 5'(r * 3 + 1));
    wr_udc(5, 7, 5'h1F);
    wr_udc(9, 2, 5'h15);
    tag = "R5";
    wr_char(4, 8'h85); wr_char(5, 8'hF5); wr_char(6, 8'h89);
    idle(30);
    tag = "R6"; wr_udc(5, 3, 5'h0A); idle(30);
    tag = "R3"; clk_sel = 0; idle(10);
    for (int k = 0; k < 10; k++) begin
      sync_in = 1; idle(1 + (k % 3));
      sync_in = 0; idle(2 + (k % 4));
    end
    sync_in = 1; idle(12); sync_in = 0; idle(5);
    clk_sel = 1;
    tag = "R8"; blink_en = 1; idle(260);
    tag = "R10"; test_en = 1; idle(220);
    test_en = 0;
    tag = "R9"; blink_en = 0; idle(230);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not end, exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule